// File: doc/BRIEF.md
# DRAM Command and Power-State Tracker

This block sits on the device side of a DDR3 command interface. On every rising edge of a single-ended clock it samples the clock-enable, chip-select, the three command strobes, the bank address and the address bus. From these it recognises activate, read, write, precharge, refresh and mode-register-set commands. For each accepted command it emits a one-cycle pulse carrying the command kind and the fields that command gives meaning to. These fields are the bank, the row or column, the burst-chop and auto-precharge flags, or the mode-register index and opcode.

Alongside decoding, the block keeps an open/idle bit for each bank. It also follows the clock-enable power states. Which low-power state it enters depends on whether any row is open and on whether a refresh accompanies the falling clock-enable. Illegal bank sequences raise a protocol-error pulse. Dropping clock-enable while a read or write burst is still in flight raises a separate error pulse. The data path, calibration, termination and refresh timing are handled elsewhere.

Top module: `dram_cmd_tracker`

## Requirements
- R1: A command sampled with csN high is masked: no cmdValid, no protoErr and no bank change, whatever rasN, casN and weN are.
- R2: While awake with cke high, {rasN,casN,weN} decodes as 011 activate (cmdKind 1), 101 read (2), 100 write (3), 010 precharge (4), 001 refresh (5) and 000 mode-register set (6). Codes 111 and 110 are no-ops. An accepted command gives cmdValid high for exactly the cycle after the edge that sampled it, and every field output is zero whenever cmdValid is low.
- R3: For activate, read, write and precharge, cmdBank equals ba. An accepted activate sets bankOpen[ba]. Reset clears all of bankOpen.
- R4: For activate, cmdAddr is the full address bus (row). For read and write, cmdAddr is the column {A11, A9..A0} zero-extended, with A10 and A12 left out. For other commands it is zero.
- R5: burstChop is 1 for a read or write sampled with A12 low, and 0 otherwise.
- R6: A10 is the auto-precharge flag: autoPre equals A10 on read, write and precharge. A precharge with A10 high closes every bank, and one with A10 low closes bank ba. A read or write with A10 high closes bank ba.
- R7: For a mode-register set, mrIndex equals ba and mrOpcode equals the address bus. Both are zero for every other command.
- R8: An activate to an open bank, or a read or write to an idle bank, gives a one-cycle protoErr with no cmdValid and leaves bankOpen unchanged.
- R9: An edge that samples cke low while awake emits no command and sets pwrState (0 awake, 1 precharge power-down, 2 active power-down, 3 self-refresh). It goes to 3 if a refresh with csN low accompanies it and all banks are idle, otherwise to 2 if any bank is open, otherwise to 1.
- R10: In any low-power state all command inputs are ignored. The first edge that samples cke high returns pwrState to 0 and ignores the command on that edge.
- R11: In self-refresh, pwrState reads 0 as soon as cke is high, before any clock edge.
- R12: ckeErr pulses for one cycle after an edge that samples cke low while awake within the burst window. The window covers the 4 edges following an accepted read or write, or the 2 edges following one with A12 low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 14 | Address bus |
| cmdValid | output | 1 | Accepted-command pulse |
| cmdKind | output | 3 | Command kind code |
| cmdBank | output | 3 | Addressed bank |
| cmdAddr | output | 14 | Row or column |
| burstChop | output | 1 | On-the-fly burst chop requested |
| autoPre | output | 1 | Auto-precharge or all-bank flag |
| mrIndex | output | 3 | Mode register selected |
| mrOpcode | output | 14 | Mode register opcode |
| bankOpen | output | 8 | Per-bank open bit |
| pwrState | output | 2 | Power state code |
| protoErr | output | 1 | Illegal bank sequence pulse |
| ckeErr | output | 1 | Clock enable dropped during burst |

## Verification
Several invariants are checked on every cycle. A protocol error never coincides with a command pulse, and a masked or sleeping cycle never yields a command. Active power-down always holds an open row and self-refresh never does. An activate pulse shows its bank open, and an all-bank precharge leaves none open. A ckeErr pulse always follows a low clock-enable. Only the bench's scenarios can show that each field carries the right value, that the power state chosen on entry matches the bank state, that the exact burst window length is respected, and that self-refresh exit shows up between clock edges.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;

  typedef enum logic [1:0] {
    PWR_AWAKE    = 2'd0,
    PWR_PDN_PRE  = 2'd1,
    PWR_PDN_ACT  = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwrT;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_ACT   = 3'd1,
    KIND_READ  = 3'd2,
    KIND_WRITE = 3'd3,
    KIND_PRE   = 3'd4,
    KIND_REF   = 3'd5,
    KIND_MRS   = 3'd6
  } kindT;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic refr;
    logic mrs;
  } strobeT;

  // address bits whose meaning the decoder depends on
  localparam int AP_BIT = 10;
  localparam int BC_BIT = 12;

endpackage

// File: rtl/dram_cmd_ctrl.sv
module dram_cmd_ctrl
  import dram_cmd_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int BURST_CLKS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic                       chopBit,
  input  logic [BANKS-1:0]           bankOpen,
  output strobeT                     strobe,
  output pwrT                        pwrState,
  output logic                       protoErr,
  output logic                       ckeErr
);

  localparam int CNT_W = $clog2(BURST_CLKS + 1);

  pwrT              stateQ, stateD;
  logic [CNT_W-1:0] burstQ;
  logic [2:0]       code;
  logic             live, openHit, anyOpen;
  logic             isAct, isRw, isPre, isRef, isMrs;
  logic             badCmd, ckeDrop;

  assign code    = {rasN, casN, weN};
  assign live    = (stateQ == PWR_AWAKE) && cke && !csN;
  assign openHit = bankOpen[ba];
  assign anyOpen = |bankOpen;

  assign isAct = (code == 3'b011);
  assign isRw  = rasN && !casN;
  assign isPre = (code == 3'b010);
  assign isRef = (code == 3'b001);
  assign isMrs = (code == 3'b000);

  always_comb begin
    strobe      = '0;
    strobe.act  = live && isAct && !openHit;
    strobe.rd   = live && isRw && weN && openHit;
    strobe.wr   = live && isRw && !weN && openHit;
    strobe.pre  = live && isPre;
    strobe.refr = live && isRef;
    strobe.mrs  = live && isMrs;
  end

  assign badCmd  = live && ((isAct && openHit) || (isRw && !openHit));
  assign ckeDrop = (stateQ == PWR_AWAKE) && !cke;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      PWR_AWAKE: begin
        if (!cke) begin
          if (!csN && isRef && !anyOpen) stateD = PWR_SELF_REF;
          else if (anyOpen)              stateD = PWR_PDN_ACT;
          else                           stateD = PWR_PDN_PRE;
        end
      end
      default: begin
        if (cke) stateD = PWR_AWAKE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= PWR_AWAKE;
      burstQ   <= '0;
      protoErr <= 1'b0;
      ckeErr   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      protoErr <= badCmd;
      ckeErr   <= ckeDrop && (burstQ != '0);
      if (strobe.rd || strobe.wr)
        burstQ <= chopBit ? CNT_W'(BURST_CLKS) : CNT_W'(BURST_CLKS / 2);
      else if (burstQ != '0)
        burstQ <= burstQ - CNT_W'(1);
    end
  end

  // self-refresh exit seen as soon as clock enable rises
  assign pwrState = ((stateQ == PWR_SELF_REF) && cke) ? PWR_AWAKE : stateQ;

endmodule

// File: rtl/dram_cmd_path.sv
module dram_cmd_path
  import dram_cmd_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ADDR_W = 14
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strobe,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       cmdValid,
  output logic [2:0]                 cmdKind,
  output logic [$clog2(BANKS)-1:0]   cmdBank,
  output logic [ADDR_W-1:0]          cmdAddr,
  output logic                       burstChop,
  output logic                       autoPre,
  output logic [$clog2(BANKS)-1:0]   mrIndex,
  output logic [ADDR_W-1:0]          mrOpcode,
  output logic [BANKS-1:0]           bankOpen
);

  localparam int BA_W = $clog2(BANKS);

  kindT              kindD;
  logic [BA_W-1:0]   bankD, mrIdxD;
  logic [ADDR_W-1:0] addrD, mrOpD, col;
  logic              chopD, apD, rwHit;

  assign rwHit = strobe.rd || strobe.wr;

  always_comb begin
    col = '0;
    col[AP_BIT:0] = {addr[AP_BIT+1], addr[AP_BIT-1:0]};
    kindD  = KIND_NONE;
    bankD  = '0;
    addrD  = '0;
    chopD  = 1'b0;
    apD    = 1'b0;
    mrIdxD = '0;
    mrOpD  = '0;
    if (strobe.act) begin
      kindD = KIND_ACT;
      bankD = ba;
      addrD = addr;
    end else if (rwHit) begin
      kindD = strobe.rd ? KIND_READ : KIND_WRITE;
      bankD = ba;
      addrD = col;
      chopD = !addr[BC_BIT];
      apD   = addr[AP_BIT];
    end else if (strobe.pre) begin
      kindD = KIND_PRE;
      bankD = ba;
      apD   = addr[AP_BIT];
    end else if (strobe.refr) begin
      kindD = KIND_REF;
    end else if (strobe.mrs) begin
      kindD  = KIND_MRS;
      mrIdxD = ba;
      mrOpD  = addr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      cmdKind   <= 3'd0;
      cmdBank   <= '0;
      cmdAddr   <= '0;
      burstChop <= 1'b0;
      autoPre   <= 1'b0;
      mrIndex   <= '0;
      mrOpcode  <= '0;
    end else begin
      cmdValid  <= (kindD != KIND_NONE);
      cmdKind   <= kindD;
      cmdBank   <= bankD;
      cmdAddr   <= addrD;
      burstChop <= chopD;
      autoPre   <= apD;
      mrIndex   <= mrIdxD;
      mrOpcode  <= mrOpD;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit, openBit;
    assign hit = (ba == BA_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        openBit <= 1'b0;
      else if (strobe.act && hit)
        openBit <= 1'b1;
      else if (strobe.pre && (addr[AP_BIT] || hit))
        openBit <= 1'b0;
      else if (rwHit && addr[AP_BIT] && hit)
        openBit <= 1'b0;
    end
    assign bankOpen[g] = openBit;
  end

endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dram_cmd_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int ADDR_W     = 14,
  parameter int BURST_CLKS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       cmdValid,
  output logic [2:0]                 cmdKind,
  output logic [$clog2(BANKS)-1:0]   cmdBank,
  output logic [ADDR_W-1:0]          cmdAddr,
  output logic                       burstChop,
  output logic                       autoPre,
  output logic [$clog2(BANKS)-1:0]   mrIndex,
  output logic [ADDR_W-1:0]          mrOpcode,
  output logic [BANKS-1:0]           bankOpen,
  output logic [1:0]                 pwrState,
  output logic                       protoErr,
  output logic                       ckeErr
);

  localparam int BA_W = $clog2(BANKS);

  strobeT strobe;
  pwrT    pwrInt;

  dram_cmd_ctrl #(.BANKS(BANKS), .BURST_CLKS(BURST_CLKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba),
    .chopBit(addr[BC_BIT]), .bankOpen(bankOpen),
    .strobe(strobe), .pwrState(pwrInt),
    .protoErr(protoErr), .ckeErr(ckeErr)
  );

  dram_cmd_path #(.BANKS(BANKS), .ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ba(ba), .addr(addr),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .burstChop(burstChop), .autoPre(autoPre),
    .mrIndex(mrIndex), .mrOpcode(mrOpcode), .bankOpen(bankOpen)
  );

  assign pwrState = pwrInt;

endmodule

// File: rtl/dram_cmd_checker.sv
module dram_cmd_checker #(
  parameter int BANKS = 8,
  parameter int BA_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cke,
  input logic             csN,
  input logic             cmdValid,
  input logic [2:0]       cmdKind,
  input logic [BA_W-1:0]  cmdBank,
  input logic             burstChop,
  input logic             autoPre,
  input logic [BANKS-1:0] bankOpen,
  input logic [1:0]       pwrState,
  input logic             protoErr,
  input logic             ckeErr
);

  // R8
  no_err_with_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !cmdValid);

  // R1
  masked_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && pwrState == 2'd0) |=> (!cmdValid && !protoErr));

  // R10
  asleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd0) |=> !cmdValid);

  // R9
  active_pdn_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2) |-> (bankOpen != '0));

  // R9
  self_ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3) |-> (bankOpen == '0));

  // R12
  cke_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ckeErr |-> !$past(cke));

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'd1) |-> bankOpen[cmdBank]);

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'd4 && autoPre) |-> (bankOpen == '0));

  // R5
  chop_only_rw_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstChop |-> (cmdValid && (cmdKind == 3'd2 || cmdKind == 3'd3)));

  // R2
  kind_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdKind != 3'd0 && cmdKind != 3'd7));

endmodule

bind dram_cmd_tracker dram_cmd_checker #(.BANKS(BANKS), .BA_W(BA_W)) i_checker (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .cmdValid(cmdValid),
  .cmdKind(cmdKind), .cmdBank(cmdBank), .burstChop(burstChop),
  .autoPre(autoPre), .bankOpen(bankOpen), .pwrState(pwrState),
  .protoErr(protoErr), .ckeErr(ckeErr)
);

// File: tb/test_dram_cmd_tracker.sv
module test_dram_cmd_tracker;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                         C_NOP = 3'b111;

  logic clk = 1'b0, rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [2:0]  ba = '0;
  logic [13:0] addr = '0;
  logic        cmdValid, burstChop, autoPre, protoErr, ckeErr;
  logic [2:0]  cmdKind, cmdBank, mrIndex;
  logic [13:0] cmdAddr, mrOpcode;
  logic [7:0]  bankOpen;
  logic [1:0]  pwrState;

  int nChecks = 0, nErr = 0;
  int mState = 0, mBurst = 0;
  logic [7:0] mOpen = '0;

  always #10 clk = ~clk;

  dram_cmd_tracker i_dram_cmd_tracker (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .burstChop(burstChop), .autoPre(autoPre),
    .mrIndex(mrIndex), .mrOpcode(mrOpcode), .bankOpen(bankOpen),
    .pwrState(pwrState), .protoErr(protoErr), .ckeErr(ckeErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic cs, input logic [2:0] code,
                      input logic [2:0] b, input logic [13:0] a);
    int eKind, eBank, eAddr, eChop, eAp, eMrI, eMrO, eProto, eCke, nb;
    eKind = 0; eBank = 0; eAddr = 0; eChop = 0; eAp = 0;
    eMrI = 0; eMrO = 0; eProto = 0; eCke = 0; nb = 0;
    @(negedge clk);
    cke = c; csN = cs; {rasN, casN, weN} = code; ba = b; addr = a;
    #2;
    chk("R11 mid-cycle pwrState", pwrState, (mState == 3 && c) ? 0 : mState);
    if (mState == 0) begin
      if (c) begin
        if (!cs) begin
          case (code)
            C_ACT: if (mOpen[b]) eProto = 1;
                   else begin eKind = 1; eBank = b; eAddr = a; mOpen[b] = 1'b1; end
            C_RD, C_WR: if (!mOpen[b]) eProto = 1;
                   else begin
                     eKind = (code == C_RD) ? 2 : 3; eBank = b;
                     eAddr = {a[11], a[9:0]}; eChop = !a[12]; eAp = a[10];
                     if (a[10]) mOpen[b] = 1'b0;
                     nb = a[12] ? 4 : 2;
                   end
            C_PRE: begin
                     eKind = 4; eBank = b; eAp = a[10];
                     if (a[10]) mOpen = '0; else mOpen[b] = 1'b0;
                   end
            C_REF: eKind = 5;
            C_MRS: begin eKind = 6; eMrI = b; eMrO = a; end
            default: ;
          endcase
        end
      end else begin
        eCke = (mBurst != 0);
        if (!cs && code == C_REF && mOpen == '0) mState = 3;
        else if (mOpen != '0)                    mState = 2;
        else                                     mState = 1;
      end
    end else if (c) begin
      mState = 0;
    end
    if (nb != 0) mBurst = nb;
    else if (mBurst > 0) mBurst--;
    @(posedge clk); #1;
    chk("R2 cmdValid", cmdValid, eKind != 0);
    chk("R2 cmdKind", cmdKind, eKind);
    chk("R3 cmdBank", cmdBank, eBank);
    chk("R4 cmdAddr", cmdAddr, eAddr);
    chk("R5 burstChop", burstChop, eChop);
    chk("R6 autoPre", autoPre, eAp);
    chk("R7 mrIndex", mrIndex, eMrI);
    chk("R7 mrOpcode", mrOpcode, eMrO);
    chk("R8 protoErr", protoErr, eProto);
    chk("R12 ckeErr", ckeErr, eCke);
    chk("R3 R6 bankOpen", bankOpen, mOpen);
    chk("R9 R10 pwrState", pwrState, (mState == 3 && c) ? 0 : mState);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog (all requirements) actual 200000 cycles expected fewer");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2;
    chk("R2 reset cmdValid", cmdValid, 0);
    chk("R3 reset bankOpen", bankOpen, 0);
    chk("R9 reset pwrState", pwrState, 0);

    step(1, 0, C_ACT, 3'd2, 14'h1234);              // R3 R4 open bank 2
    step(1, 0, C_RD,  3'd2, 14'h0A55);              // R5 A12 low: chop
    step(0, 1, C_NOP, 3'd0, 14'h0);                 // R12 R9 drop in window, row open
    chk("R9 active power-down", pwrState, 2);
    step(0, 0, C_ACT, 3'd5, 14'h0);                 // R10 ignored while down
    chk("R10 bank5 untouched", bankOpen[5], 0);
    step(1, 0, C_ACT, 3'd5, 14'h0);                 // R10 exit edge ignored
    chk("R10 exit edge no pulse", cmdValid, 0);
    step(1, 0, C_WR,  3'd2, 14'h1400);              // R6 write with auto-precharge
    step(1, 1, C_ACT, 3'd3, 14'h0);                 // R1 masked
    chk("R1 masked no pulse", cmdValid, 0);
    chk("R1 masked bank state", bankOpen, 0);
    step(1, 0, C_RD,  3'd4, 14'h0);                 // R8 read to idle bank
    step(1, 0, C_ACT, 3'd1, 14'h0777);
    step(1, 0, C_ACT, 3'd1, 14'h0111);              // R8 activate to open bank
    step(1, 0, C_ACT, 3'd6, 14'h2222);
    step(1, 0, C_PRE, 3'd0, 14'h0400);              // R6 all-bank precharge
    step(1, 0, C_MRS, 3'd2, 14'h0ABC);              // R7
    repeat (5) step(1, 1, C_NOP, 3'd0, 14'h0);
    step(0, 1, C_NOP, 3'd0, 14'h0);                 // R9 precharge power-down
    chk("R9 precharge power-down", pwrState, 1);
    step(1, 1, C_NOP, 3'd0, 14'h0);
    step(0, 0, C_REF, 3'd0, 14'h0);                 // R9 self-refresh entry
    chk("R9 self-refresh", pwrState, 3);
    step(0, 0, C_MRS, 3'd1, 14'h0F0F);              // R10 ignored in self-refresh
    step(1, 1, C_NOP, 3'd0, 14'h0);                 // R11 exit seen mid-cycle

    for (int i = 0; i < 4000; i++) begin
      logic c, cs;
      c  = ($urandom % 10) != 0;
      cs = ($urandom % 8) == 0;
      step(c, cs, 3'($urandom), 3'($urandom), 14'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule